// File: doc/BRIEF.md
# Indirect Register Access Bridge

The bridge gives a 32-bit host a path into a wide internal register space through a pair of direct registers. The host first loads a 32-bit target address into the address register. It then reads or writes the data register. Each data-register access becomes one read or one write of a single 16-bit internal register.

Each internal value travels in the upper half of the 32-bit host word. A small internal register file is built in, which keeps the block testable at its own ports. It holds a contiguous window of 16-bit registers spaced 4 bytes apart. A parameter mask marks some of its slots as reserved.

The host bus is synchronous and single-cycle, with a direct offset, write data, read data, a read strobe and a write strobe. Read data is registered and appears in the cycle after the read strobe. The reset input is asynchronous and active-low, and its release is synchronised to the clock inside the block.

Top module: `irb_bridge`

## Requirements
- R1: After reset, reads of the address register and of every internal register return zero, and `host_rdata` is zero.
- R2: Direct offset 0xB is the 32-bit address register. A write stores all 32 bits, and a read returns the stored value in the cycle after the read strobe.
- R3: A write to direct offset 0xC sends host bits [31:16] to the internal register selected by the address register and discards bits [15:0]. The internal write strobe is raised in the cycle after the host write strobe.
- R4: A read of direct offset 0xC returns the selected internal register in bits [31:16] and zero in bits [15:0]. The data is valid in the cycle after the read strobe.
- R5: The address register keeps its value across data accesses, so repeated data accesses reach the same internal register.
- R6: Internal register k sits at BASE_ADDR + 4*k for k from 0 to NUM_REGS-1, and only addresses with bits [1:0] equal to zero select a register.
- R7: An internal address that is outside the window, misaligned, or in a reserved slot (slots 4 and 5 with the default mask) reads as zero. A write to such an address changes no internal register.
- R8: A data read issued in the cycle right after a data write returns the newly written value.
- R9: Direct offsets other than 0xB and 0xC read as zero, and writes to them change neither the address register nor any internal register.
- R10: `host_rdata` is zero in every cycle that does not follow a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 4 | Direct register offset |
| host_wdata | input | 32 | Host write data |
| host_wr | input | 1 | Host write strobe, one cycle per access |
| host_rd | input | 1 | Host read strobe, one cycle per access |
| host_rdata | output | 32 | Registered read data, valid the cycle after `host_rd` |

## Verification
On every cycle the assertions check the following:
- the internal write strobe follows a host data write by exactly one cycle and carries the upper half of that write;
- the low half of a data read is zero;
- read data is quiet when no read strobe came before it;
- the address register is stable unless it was written;
- at most one slot is written, and a write that hits no slot leaves the whole file unchanged.

Some behaviour only the bench scenarios can show. These are the mapping of each address to the correct slot, the treatment of misaligned and reserved addresses, and forwarding in the read that directly follows a write. The bench sweeps every address in and around the window and compares each value with a model it keeps itself.

// File: rtl/irb_pkg.sv
package irb_pkg;
  localparam int HOST_W = 32;
  localparam int REG_W  = 16;
  localparam int DIR_AW = 4;

  localparam logic [DIR_AW-1:0] OFF_ADDR = 4'hB;
  localparam logic [DIR_AW-1:0] OFF_DATA = 4'hC;

  typedef struct packed {
    logic              vld;
    logic [HOST_W-1:0] addr;
    logic [REG_W-1:0]  data;
  } irb_wreq_t;
endpackage

// File: rtl/irb_slot_decode.sv
module irb_slot_decode #(
  parameter logic [31:0]         BASE_ADDR = 32'hFFFF1400,
  parameter int                  NUM_REGS  = 8,
  parameter logic [NUM_REGS-1:0] RSV_MASK  = '0,
  localparam int                 IDX_W     = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic [31:0]      addr,
  output logic             hit,
  output logic [IDX_W-1:0] idx
);
  logic [31:0] offset;
  logic        in_range;
  logic        aligned;

  always_comb begin
    offset   = addr - BASE_ADDR;
    aligned  = (addr[1:0] == 2'b00);
    in_range = (offset[31:2] < 30'(NUM_REGS));
    idx      = offset[IDX_W+1:2];
    hit      = aligned && in_range && !RSV_MASK[idx];
  end
endmodule

// File: rtl/irb_regfile.sv
module irb_regfile #(
  parameter logic [31:0]         BASE_ADDR = 32'hFFFF1400,
  parameter int                  NUM_REGS  = 8,
  parameter logic [NUM_REGS-1:0] RSV_MASK  = '0,
  parameter int                  REG_W     = 16,
  localparam int                 IDX_W     = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [31:0]      wr_addr,
  input  logic [REG_W-1:0] wr_data,
  input  logic [31:0]      rd_addr,
  output logic [REG_W-1:0] rd_data,
  output logic             rd_hit
);
  logic             wr_hit;
  logic [IDX_W-1:0] wr_idx;
  logic [IDX_W-1:0] rd_idx;
  logic [NUM_REGS-1:0] slot_we;
  logic [NUM_REGS-1:0][REG_W-1:0] slot_q;

  irb_slot_decode #(.BASE_ADDR(BASE_ADDR), .NUM_REGS(NUM_REGS), .RSV_MASK(RSV_MASK))
    u_wr_dec (.addr(wr_addr), .hit(wr_hit), .idx(wr_idx));

  irb_slot_decode #(.BASE_ADDR(BASE_ADDR), .NUM_REGS(NUM_REGS), .RSV_MASK(RSV_MASK))
    u_rd_dec (.addr(rd_addr), .hit(rd_hit), .idx(rd_idx));

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_slot
    always_comb slot_we[i] = wr_en && wr_hit && (wr_idx == IDX_W'(i));

    if (RSV_MASK[i]) begin : g_rsv
      assign slot_q[i] = '0;
    end else begin : g_store
      logic [REG_W-1:0] val_d;
      logic [REG_W-1:0] val_q;

      always_comb begin
        val_d = val_q;
        if (slot_we[i]) val_d = wr_data;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          val_q <= '0;
        else if (slot_we[i]) val_q <= val_d;
      end

      assign slot_q[i] = val_q;
    end
  end

  always_comb rd_data = rd_hit ? slot_q[rd_idx] : '0;

  AST_ONE_SLOT_WRITTEN: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(slot_we)); // R6
  AST_MISS_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_hit) |=> $stable(slot_q)); // R7
  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(slot_q)); // R3
endmodule

// File: rtl/irb_host_if.sv
module irb_host_if
  import irb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIR_AW-1:0] host_addr,
  input  logic [HOST_W-1:0] host_wdata,
  input  logic              host_wr,
  input  logic              host_rd,
  output logic [HOST_W-1:0] host_rdata,
  output logic [HOST_W-1:0] iaddr,
  output irb_wreq_t         wreq,
  input  logic [REG_W-1:0]  int_rdata,
  input  logic              int_hit
);
  logic [HOST_W-1:0] addr_d, addr_q;
  logic              addr_en;
  irb_wreq_t         wreq_d, wreq_q;
  logic [HOST_W-1:0] rdata_d, rdata_q;
  logic [REG_W-1:0]  fwd_val;

  always_comb begin
    addr_en = host_wr && (host_addr == OFF_ADDR);
    addr_d  = host_wdata;
  end

  always_comb begin
    wreq_d.vld  = host_wr && (host_addr == OFF_DATA);
    wreq_d.addr = addr_q;
    wreq_d.data = host_wdata[HOST_W-1:REG_W];
  end

  always_comb begin
    fwd_val = (wreq_q.vld && int_hit) ? wreq_q.data : int_rdata;
    rdata_d = '0;
    if (host_rd) begin
      unique case (host_addr)
        OFF_ADDR: rdata_d = addr_q;
        OFF_DATA: rdata_d = {fwd_val, {(HOST_W-REG_W){1'b0}}};
        default:  rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (addr_en) addr_q <= addr_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wreq_q  <= '0;
      rdata_q <= '0;
    end else begin
      wreq_q  <= wreq_d;
      rdata_q <= rdata_d;
    end
  end

  assign iaddr      = addr_q;
  assign wreq       = wreq_q;
  assign host_rdata = rdata_q;

  AST_WR_ONE_CYCLE_LATE: assert property (@(posedge clk) disable iff (!rst_n)
    wreq_q.vld |-> ($past(host_wr) && ($past(host_addr) == OFF_DATA))); // R3
  AST_WR_UPPER_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    wreq_q.vld |-> (wreq_q.data == $past(host_wdata[HOST_W-1:REG_W]))); // R3
  AST_DATA_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(host_rd) && ($past(host_addr) == OFF_DATA)) |-> (host_rdata[REG_W-1:0] == '0)); // R4
  AST_RDATA_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(host_rd) |-> (host_rdata == '0)); // R10
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !($past(host_wr) && ($past(host_addr) == OFF_ADDR)) |-> $stable(addr_q)); // R5
endmodule

// File: rtl/irb_bridge.sv
module irb_bridge
  import irb_pkg::*;
#(
  parameter logic [31:0]         BASE_ADDR = 32'hFFFF1400,
  parameter int                  NUM_REGS  = 8,
  parameter logic [NUM_REGS-1:0] RSV_MASK  = 8'b0011_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIR_AW-1:0] host_addr,
  input  logic [HOST_W-1:0] host_wdata,
  input  logic              host_wr,
  input  logic              host_rd,
  output logic [HOST_W-1:0] host_rdata
);
  logic [1:0]        rst_pipe;
  logic              rst_sync_n;
  logic [HOST_W-1:0] iaddr;
  irb_wreq_t         wreq;
  logic [REG_W-1:0]  int_rdata;
  logic              int_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  irb_host_if u_host (
    .clk(clk), .rst_n(rst_sync_n),
    .host_addr(host_addr), .host_wdata(host_wdata),
    .host_wr(host_wr), .host_rd(host_rd), .host_rdata(host_rdata),
    .iaddr(iaddr), .wreq(wreq),
    .int_rdata(int_rdata), .int_hit(int_hit)
  );

  irb_regfile #(.BASE_ADDR(BASE_ADDR), .NUM_REGS(NUM_REGS), .RSV_MASK(RSV_MASK),
                .REG_W(REG_W)) u_rf (
    .clk(clk), .rst_n(rst_sync_n),
    .wr_en(wreq.vld), .wr_addr(wreq.addr), .wr_data(wreq.data),
    .rd_addr(iaddr), .rd_data(int_rdata), .rd_hit(int_hit)
  );
endmodule

// File: tb/test_irb_bridge.sv
module test_irb_bridge;
  localparam logic [31:0] BASE = 32'hFFFF1400;
  localparam int NREG = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic        host_wr = 1'b0;
  logic        host_rd = 1'b0;
  logic [31:0] host_rdata;

  int checks = 0;
  int fails  = 0;
  logic [15:0] model [NREG];
  logic [31:0] got;

  irb_bridge i_irb_bridge (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_wr(host_wr), .host_rd(host_rd), .host_rdata(host_rdata)
  );

  always #2 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] off, input logic [31:0] d);
    host_addr = off; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0; host_wdata = '0;
  endtask

  task automatic rd(input logic [3:0] off, output logic [31:0] d);
    host_addr = off; host_rd = 1'b1;
    @(negedge clk);
    host_rd = 1'b0;
    d = host_rdata;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  function automatic bit mapped(input logic [31:0] a);
    logic [31:0] off;
    off = a - BASE;
    if (a[1:0] != 2'b00) return 0;
    if (off[31:2] >= NREG) return 0;
    if (off[31:2] == 4 || off[31:2] == 5) return 0;
    return 1;
  endfunction

  function automatic logic [31:0] expect_rd(input logic [31:0] a);
    if (!mapped(a)) return 32'h0;
    return {model[(a - BASE) >> 2], 16'h0000};
  endfunction

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < NREG; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    check("R1 rdata", host_rdata, 32'h0);
    rd(4'hB, got); check("R1 addr reg", got, 32'h0);
    for (int k = 0; k < NREG; k++) begin
      wr(4'hB, BASE + 32'(4*k));
      rd(4'hC, got); check("R1 internal", got, 32'h0);
    end

    // R2 address register round trip
    wr(4'hB, 32'hA5C3_0F96); rd(4'hB, got); check("R2 addr", got, 32'hA5C3_0F96);
    wr(4'hB, 32'h0000_0001); rd(4'hB, got); check("R2 addr", got, 32'h0000_0001);

    // R3 R4 basic example: upper half stored, lower half discarded
    wr(4'hB, BASE + 32'h8);
    wr(4'hC, 32'h0802_FFFF); idle();
    model[2] = 16'h0802;
    rd(4'hC, got); check("R3 R4 example", got, 32'h0802_0000);
    idle(); check("R10 quiet", host_rdata, 32'h0);

    // R6 R7 sweep: write a distinct pattern to every address around the window
    for (int a = -8; a < NREG*4 + 8; a++) begin
      logic [31:0] ad;
      logic [15:0] v;
      ad = BASE + 32'(a);
      v  = 16'h1000 + 16'(a * 37);
      wr(4'hB, ad);
      wr(4'hC, {v, 16'hBEEF}); idle();
      if (mapped(ad)) model[(ad - BASE) >> 2] = v;
    end
    for (int a = -8; a < NREG*4 + 8; a++) begin
      logic [31:0] ad;
      ad = BASE + 32'(a);
      wr(4'hB, ad);
      rd(4'hC, got);
      check(mapped(ad) ? "R6 mapped read" : "R7 unmapped read", got, expect_rd(ad));
    end

    // R5 address held across repeated data accesses
    wr(4'hB, BASE + 32'h4);
    wr(4'hC, 32'h1111_0000); idle();
    wr(4'hC, 32'h2222_1234); idle();
    model[1] = 16'h2222;
    rd(4'hC, got); check("R5 same target", got, 32'h2222_0000);
    rd(4'hB, got); check("R5 addr kept", got, BASE + 32'h4);
    rd(4'hC, got); check("R5 repeat read", got, 32'h2222_0000);

    // R8 read directly after write
    for (int k = 0; k < NREG; k++) begin
      logic [31:0] ad;
      logic [15:0] v;
      ad = BASE + 32'(4*k);
      v  = 16'hC000 ^ 16'(k * 16'h0101);
      wr(4'hB, ad);
      wr(4'hC, {v, 16'h5555});
      if (mapped(ad)) model[k] = v;
      rd(4'hC, got); check("R8 back to back", got, expect_rd(ad));
    end

    // R9 other offsets: read zero, writes ignored
    wr(4'hB, BASE);
    for (int o = 0; o < 16; o++) begin
      if (o == 11 || o == 12) continue;
      wr(4'(o), 32'hDEAD_BEEF); idle();
      rd(4'(o), got); check("R9 other offset", got, 32'h0);
    end
    rd(4'hB, got); check("R9 addr untouched", got, BASE);
    rd(4'hC, got); check("R9 data untouched", got, expect_rd(BASE));

    // R10 quiet after reads
    idle(); check("R10 quiet", host_rdata, 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule